// File: doc/BRIEF.md
# RS-485 Driver-Enable Guard Timer

This block sits between a UART transmitter and an RS-485 line driver and owns the driver-enable line. When the transmitter reports that a frame is waiting, the block turns the line driver on. It then counts a programmable number of oversampling ticks before it lets the transmitter start the start bit. When the transmitter reports that the last stop bit of the final frame has left the wire, the block keeps the driver on for a second programmable number of ticks and then releases the line.

Both guard intervals are counted in oversampling ticks, which come in from the baud generator as a one-cycle strobe. In the by-16 oversampling mode a tick is a sixteenth of a bit; in the by-8 mode it is an eighth. The mode bit is held here with the two guard values and is passed on to the baud generator. The three configuration fields can only be written while the peripheral enable is low. Dropping the enable turns the driver off at once.

Top module: `rs485_de_ctrl`

## Requirements
- R1: After a synchronous reset, `de_o` and `go_o` are 0, both guard values are 0, and `ovs8_o` is 0, which means oversampling by 16.
- R2: With a nonzero lead value L, a pending frame seen while idle and enabled sets `de_o` on the next clock. `go_o` then rises on the clock that consumes the L-th tick strobe, and `go_o` is never 1 while `de_o` is 0.
- R3: With a lead value of 0, `de_o` and `go_o` rise together on the clock after the pending frame is first seen.
- R4: With a nonzero trail value T, a transmit-complete pulse with no frame pending drops `go_o` on the next clock. `de_o` stays 1 and falls on the clock that consumes the T-th tick after that.
- R5: With a trail value of 0, `de_o` and `go_o` both fall on the clock right after the transmit-complete pulse.
- R6: The guard counters advance only on clocks where `tick_i` is 1. If no tick arrives, the block waits in the lead or trail interval for as long as that lasts.
- R7: A frame that becomes pending during the trail interval raises `go_o` on the next clock, with no new lead interval and with `de_o` kept at 1. This holds even when that clock also carries the tick that would end the trail interval.
- R8: A transmit-complete pulse while a frame is still pending leaves `de_o` and `go_o` at 1, so frames can follow back to back.
- R9: While `enable_i` is 0, both outputs are 0 on the next clock and the block returns to idle. Pending frames are ignored while the enable is low.
- R10: A configuration write (`cfg_we_i`) takes effect only while `enable_i` is 0. While the enable is 1, the write changes neither the guard lengths nor `ovs8_o`.
- R11: `ovs8_o` shows the stored mode bit: 0 selects oversampling by 16 and 1 selects oversampling by 8. The guard lengths stay counted in ticks whichever mode is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling tick strobe, one cycle wide |
| enable_i | input | 1 | Peripheral enable; 0 forces idle and opens the configuration |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_lead_i | input | DLY_W | Lead guard length in ticks |
| cfg_trail_i | input | DLY_W | Trail guard length in ticks |
| cfg_ovs8_i | input | 1 | Oversampling mode: 0 by 16, 1 by 8 |
| tx_pend_i | input | 1 | Transmitter has a frame waiting |
| tx_done_i | input | 1 | Pulse: the last stop bit has been sent |
| de_o | output | 1 | Line driver enable (registered) |
| go_o | output | 1 | Permission for the transmitter to start (registered) |
| ovs8_o | output | 1 | Stored oversampling mode for the baud generator |

## Verification
Two events can fall in the same cycle: the tick that ends the trail interval and a newly pending frame. The bench provokes this by asserting pending on the exact cycle whose tick would be the last trail tick. It then checks that the driver-enable never drops and that `go_o` returns on the next clock, so the pending frame wins. A second overlap is a completed frame whose pulse arrives while another frame is pending. That case is judged by `de_o` and `go_o` staying high across the pulse.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SEND  = 2'd2,
    ST_TRAIL = 2'd3
  } de_state_e;
endpackage

// File: rtl/rs485_de_cfg.sv
module rs485_de_cfg #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [DLY_W-1:0] lead_i,
  input  logic [DLY_W-1:0] trail_i,
  input  logic             ovs8_i,
  output logic [DLY_W-1:0] lead_o,
  output logic [DLY_W-1:0] trail_o,
  output logic             ovs8_o
);
  logic [DLY_W-1:0] lead_q, trail_q;
  logic             ovs8_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_q  <= '0;
      trail_q <= '0;
      ovs8_q  <= 1'b0;
    end else if (we_i && !en_i) begin
      lead_q  <= lead_i;
      trail_q <= trail_i;
      ovs8_q  <= ovs8_i;
    end
  end

  assign lead_o  = lead_q;
  assign trail_o = trail_q;
  assign ovs8_o  = ovs8_q;

  // R10: fields frozen while enabled
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    en_i |=> ($stable(lead_q) && $stable(trail_q) && $stable(ovs8_q)));
endmodule

// File: rtl/rs485_de_guard_cnt.sv
module rs485_de_guard_cnt #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [DLY_W-1:0] limit_i,
  output logic             hit_o
);
  localparam int CW = DLY_W + 1;

  logic [DLY_W-1:0] cnt_q;
  logic [CW-1:0]    cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + CW'(1);
  assign hit_o  = adv_i && (cnt_nx == {1'b0, limit_i});

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_nx[DLY_W-1:0];
  end

  // R6: no tick, no progress
  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !adv_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rs485_de_fsm.sv
module rs485_de_fsm
  import rs485_de_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en_i,
  input  logic      pend_i,
  input  logic      done_i,
  input  logic      lead_zero_i,
  input  logic      trail_zero_i,
  input  logic      hit_i,
  output de_state_e state_o,
  output logic      de_o,
  output logic      go_o
);
  de_state_e st_q;
  logic      de_q, go_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      st_q <= ST_IDLE;
      de_q <= 1'b0;
      go_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (pend_i) begin
          de_q <= 1'b1;
          if (lead_zero_i) begin
            st_q <= ST_SEND;
            go_q <= 1'b1;
          end else begin
            st_q <= ST_LEAD;
          end
        end
        ST_LEAD: if (hit_i) begin
          st_q <= ST_SEND;
          go_q <= 1'b1;
        end
        ST_SEND: if (done_i && !pend_i) begin
          go_q <= 1'b0;
          if (trail_zero_i) begin
            st_q <= ST_IDLE;
            de_q <= 1'b0;
          end else begin
            st_q <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (pend_i) begin
            st_q <= ST_SEND;
            go_q <= 1'b1;
          end else if (hit_i) begin
            st_q <= ST_IDLE;
            de_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign de_o    = de_q;
  assign go_o    = go_q;

  // R2: transmitter never released without the driver on
  p_go_needs_de_r2: assert property (@(posedge clk) disable iff (rst)
    go_q |-> de_q);

  // R9: enable low clears both outputs next clock
  p_enable_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!de_q && !go_q));

  // R7: pending in trail returns to sending with driver held
  p_trail_retrig_r7: assert property (@(posedge clk) disable iff (rst)
    (en_i && st_q == ST_TRAIL && pend_i) |=> (de_q && go_q));

  // R5: zero trail drops the driver right after completion
  p_trail_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && st_q == ST_SEND && done_i && !pend_i && trail_zero_i) |=> !de_q);

  // R8: completion with a frame pending keeps sending
  p_back_to_back_r8: assert property (@(posedge clk) disable iff (rst)
    (en_i && st_q == ST_SEND && done_i && pend_i) |=> (de_q && go_q));
endmodule

// File: rtl/rs485_de_ctrl.sv
module rs485_de_ctrl
  import rs485_de_pkg::*;
#(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             cfg_we_i,
  input  logic [DLY_W-1:0] cfg_lead_i,
  input  logic [DLY_W-1:0] cfg_trail_i,
  input  logic             cfg_ovs8_i,
  input  logic             tx_pend_i,
  input  logic             tx_done_i,
  output logic             de_o,
  output logic             go_o,
  output logic             ovs8_o
);
  logic [DLY_W-1:0] lead_w, trail_w, limit_w;
  logic             hit_w, clr_w, adv_w;
  de_state_e        state_w;

  rs485_de_cfg #(.DLY_W(DLY_W)) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .en_i    (enable_i),
    .we_i    (cfg_we_i),
    .lead_i  (cfg_lead_i),
    .trail_i (cfg_trail_i),
    .ovs8_i  (cfg_ovs8_i),
    .lead_o  (lead_w),
    .trail_o (trail_w),
    .ovs8_o  (ovs8_o)
  );

  // one counter serves both guard intervals; it is cleared outside them
  assign clr_w   = !enable_i || !(state_w == ST_LEAD || state_w == ST_TRAIL);
  assign adv_w   = tick_i && !clr_w;
  assign limit_w = (state_w == ST_LEAD) ? lead_w : trail_w;

  rs485_de_guard_cnt #(.DLY_W(DLY_W)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_w),
    .adv_i   (adv_w),
    .limit_i (limit_w),
    .hit_o   (hit_w)
  );

  rs485_de_fsm fsm_i (
    .clk          (clk),
    .rst          (rst),
    .en_i         (enable_i),
    .pend_i       (tx_pend_i),
    .done_i       (tx_done_i),
    .lead_zero_i  (lead_w == '0),
    .trail_zero_i (trail_w == '0),
    .hit_i        (hit_w),
    .state_o      (state_w),
    .de_o         (de_o),
    .go_o         (go_o)
  );

  // R6: without a tick the lead interval cannot end
  p_lead_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (enable_i && state_w == ST_LEAD && !tick_i) |=> !go_o);
endmodule

// File: tb/rs485_de_ctrl_tb_top.sv
`timescale 1ns/1ps
module rs485_de_ctrl_tb_top;
  localparam int DLY_W = 5;
  localparam int NVEC  = 7;
  // {lead, trail, tick period in cycles}
  localparam int VEC [NVEC][3] = '{
    '{3, 2, 1}, '{1, 1, 2}, '{0, 4, 3}, '{5, 0, 1},
    '{31, 31, 1}, '{2, 7, 4}, '{0, 0, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, enable = 1'b0, cfg_we = 1'b0, cfg_ovs8 = 1'b0;
  logic [DLY_W-1:0] cfg_lead = '0, cfg_trail = '0;
  logic pend = 1'b0, done = 1'b0;
  logic de, go, ovs8;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rs485_de_ctrl #(.DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .enable_i(enable),
    .cfg_we_i(cfg_we), .cfg_lead_i(cfg_lead), .cfg_trail_i(cfg_trail),
    .cfg_ovs8_i(cfg_ovs8), .tx_pend_i(pend), .tx_done_i(done),
    .de_o(de), .go_o(go), .ovs8_o(ovs8)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cfg(input int l, input int t, input bit o);
    @(negedge clk);
    enable = 1'b0; cfg_we = 1'b1;
    cfg_lead = DLY_W'(l); cfg_trail = DLY_W'(t); cfg_ovs8 = o;
    @(negedge clk);
    cfg_we = 1'b0; enable = 1'b1;
    @(negedge clk);
  endtask

  // runs one frame; counts ticks consumed in the lead and trail intervals
  task automatic run_frame(input int per, output int lt, output int tt,
                           output bit same, output bit fast, output bit ok);
    int k;
    bit pd, pg, pt;
    lt = 0; tt = 0; same = 0; ok = 1; k = 0;
    @(negedge clk);
    pend = 1'b1; tick = 1'b0;
    pd = de; pg = go; pt = 0;
    forever begin
      @(negedge clk);
      if (pd && !pg && pt) lt++;
      if (de && !pd) same = go;
      pd = de; pg = go;
      if (go) break;
      k++;
      if (k > 3000) begin ok = 0; break; end
      tick = ((k % per) == per - 1); pt = tick;
    end
    pend = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    fast = !de;
    pd = de; pg = go; k = 0;
    while (de) begin
      k++;
      tick = ((k % per) == per - 1); pt = tick;
      @(negedge clk);
      if (pd && !pg && pt) tt++;
      if (go) ok = 0;
      pd = de; pg = go;
      if (k > 3000) begin ok = 0; break; end
    end
    tick = 1'b0;
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lt, tt;
    bit same, fast, ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(de == 0 && go == 0, "R1 outputs low after reset", {go, de}, 0);
    chk(ovs8 == 0, "R1 mode bit zero (by 16)", ovs8, 0);
    // R1/R3: reset guards are zero, so DE and go rise together
    enable = 1'b1; pend = 1'b1;
    @(negedge clk);
    chk(de == 1 && go == 1, "R1 R3 zero lead from reset", {go, de}, 3);
    // R8: completion while still pending keeps sending
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(de == 1 && go == 1, "R8 back to back frames", {go, de}, 3);
    pend = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(de == 0 && go == 0, "R5 zero trail from reset", {go, de}, 0);

    // table-driven frames
    for (int v = 0; v < NVEC; v++) begin
      do_cfg(VEC[v][0], VEC[v][1], v[0]);
      run_frame(VEC[v][2], lt, tt, same, fast, ok);
      chk(ok, "R2 R4 frame completes", ok, 1);
      chk(lt == VEC[v][0], "R2 R6 lead tick count", lt, VEC[v][0]);
      chk(same == (VEC[v][0] == 0), "R3 DE/go rise alignment", same, VEC[v][0] == 0);
      chk(tt == VEC[v][1], "R4 R6 trail tick count", tt, VEC[v][1]);
      chk(fast == (VEC[v][1] == 0), "R5 fall right after done", fast, VEC[v][1] == 0);
      chk(ovs8 == v[0], "R11 mode bit output", ovs8, v[0]);
    end

    // R6 and R9: stall lead without ticks, then drop enable
    do_cfg(5, 1, 0);
    pend = 1'b1; tick = 1'b0;
    repeat (12) @(negedge clk);
    chk(de == 1 && go == 0, "R6 lead stalls without tick", {go, de}, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(de == 0 && go == 0, "R9 enable low clears outputs", {go, de}, 0);
    repeat (4) @(negedge clk);
    chk(de == 0, "R9 pending ignored while disabled", de, 0);
    pend = 1'b0;
    enable = 1'b1;
    @(negedge clk);

    // R10: write while enabled is ignored
    cfg_we = 1'b1; cfg_lead = 5'd1; cfg_trail = 5'd9; cfg_ovs8 = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk(ovs8 == 0, "R10 mode unchanged by write while enabled", ovs8, 0);
    run_frame(1, lt, tt, same, fast, ok);
    chk(lt == 5, "R10 lead unchanged by write while enabled", lt, 5);
    chk(tt == 1, "R10 trail unchanged by write while enabled", tt, 1);

    // R7: new frame in the middle of the trail interval
    do_cfg(2, 6, 0);
    pend = 1'b1; tick = 1'b1;
    while (!go) @(negedge clk);
    pend = 1'b0;
    repeat (2) @(negedge clk);
    tick = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    chk(de == 1 && go == 0, "R4 in trail interval", {go, de}, 1);
    pend = 1'b1;
    @(negedge clk);
    chk(de == 1 && go == 1, "R7 retrigger mid trail skips lead", {go, de}, 3);
    pend = 1'b0;

    // R7: pending on the same clock as the last trail tick
    do_cfg(1, 3, 0);
    pend = 1'b1; tick = 1'b1;
    while (!go) @(negedge clk);
    pend = 1'b0; tick = 1'b0;
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    chk(de == 1 && go == 0, "R4 two of three trail ticks", {go, de}, 1);
    pend = 1'b1;
    @(negedge clk);
    chk(de == 1 && go == 1, "R7 pending wins over expiring tick", {go, de}, 3);
    pend = 1'b0; tick = 1'b0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(de == 1 && go == 0, "R7 fresh trail after retrigger", {go, de}, 1);

    // R11: mode bit accepted while disabled
    do_cfg(0, 0, 1);
    chk(ovs8 == 1, "R11 by-8 mode stored", ovs8, 1);
    do_cfg(0, 0, 0);
    chk(ovs8 == 0, "R11 by-16 mode stored", ovs8, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule